// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the integer register file of a RISC core in which every procedure gets its own window of registers. An instruction names a register with a flat 5-bit number. The block translates that number into a physical register using a current window pointer. Eight windows sit in a circular bank. Consecutive windows share eight registers, so arguments that a caller places in its outgoing registers appear in the callee's incoming registers and nothing has to be copied. Eight global registers lie outside the windows and look the same from every window. Global 0 is hardwired to zero.

A call strobe (`save_req`) moves the pointer to the next window down, and a return strobe (`restore_req`) moves it back up. A mask marks which windows are not available. A step onto a marked window does not move the pointer and raises a one-cycle overflow or underflow trap. Software handles the trap, spills or refills windows in memory, and updates the mask through a load port.

The file has two read ports and one write port, so one operation can read two operands and write one result per cycle. Read data is registered. When a register is read in the same cycle it is written, the read returns the new data.

Top module: `winreg_file`

## Requirements
- R1: After reset the pointer is 0, both trap outputs are low, the mask marks only window 1 as invalid, both read outputs are 0, and every register number reads 0.
- R2: Register numbers 0 to 7 are globals. Each one maps to the same physical register for every pointer value.
- R3: Register number 0 always reads 0. A write to it has no effect, even when the same register is read in the same cycle.
- R4: Numbers 8 to 15 are outgoing registers and 24 to 31 are incoming registers. After a save from window w to window w-1 (mod 8), incoming register 24+k shows the value that was held in outgoing register 8+k of window w. A restore undoes this.
- R5: Numbers 16 to 23 are local registers. Each window has its own set, so a write in one window does not change the locals of another window.
- R6: A save moves the pointer to (p-1) mod 8 and a restore moves it to (p+1) mod 8. The `cwp` output shows the new value in the cycle after the strobe. With neither strobe, the pointer does not change.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged and drives `ovf_trap` high for exactly the cycle after the strobe.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged and drives `unf_trap` high for exactly the cycle after the strobe.
- R9: When both strobes are high in the same cycle, the pointer stays where it is and neither trap is raised.
- R10: A read of the physical register that is being written in the same cycle returns the newly written data (write-first).
- R11: Each read port returns, in the cycle after the address is presented, the contents of the register that the address maps to under the pointer value current at that time. A write takes effect at the same clock edge.
- R12: With `wim_we` high, the mask is loaded from `wim_data` at the clock edge. Window N is invalid when bit N is 1. Save and restore checks from the next cycle on use the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs1_idx | input | 5 | First read register number |
| rs2_idx | input | 5 | Second read register number |
| rs1_data | output | DATA_W | First read data, registered |
| rs2_data | output | DATA_W | Second read data, registered |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Move to the next window (call) |
| restore_req | input | 1 | Move to the previous window (return) |
| wim_we | input | 1 | Load the invalid-window mask |
| wim_data | input | NWIN | New invalid-window mask, bit N for window N |
| cwp | output | log2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse: save blocked by the mask |
| unf_trap | output | 1 | One-cycle pulse: restore blocked by the mask |

## Verification
The bench targets the following corner cases and the wrong behaviour each one would expose:
- **Pointer wrap, 0 to 7 on save and 7 to 0 on restore.** A design without the modulo would land outside the bank or alias the wrong window.
- **Overlap seen from both sides of a save and a restore.** A design with the wrong shift direction would show the callee stale or foreign registers.
- **Trap cases at window 1 and, after a mask reload, at window 0.** A design that steps anyway would corrupt live windows. One that latches the trap would keep it high past a single cycle.
- **Writes to global 0, a same-cycle read and write of one register, and simultaneous strobes.** A design that got these wrong would return stale data or a nonzero zero register.

A long random run with a reference model ties these cases together.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  // Pointer movement requested in one cycle
  typedef enum logic [1:0] {
    WSTEP_HOLD    = 2'd0,
    WSTEP_SAVE    = 2'd1,
    WSTEP_RESTORE = 2'd2,
    WSTEP_BOTH    = 2'd3
  } win_step_e;

  // Region selected by the top two bits of a register number
  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_OUT    = 2'd1,
    RGN_LOCAL  = 2'd2,
    RGN_IN     = 2'd3
  } reg_region_e;

  function automatic win_step_e decode_step(input logic save, input logic restore);
    return win_step_e'({restore, save});
  endfunction

endpackage

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGRP = 8,
  localparam int WSTEP = 2 * NGRP,
  localparam int WREGS = NWIN * WSTEP,
  localparam int WW    = $clog2(WREGS),
  localparam int SB    = $clog2(WSTEP),
  localparam int IDX_W = $clog2(4 * NGRP),
  localparam int PW    = $clog2(NGRP + WREGS),
  localparam int CW    = $clog2(NWIN)
) (
  input  logic [CW-1:0]    cwp,
  input  logic [IDX_W-1:0] idx,
  output logic [PW-1:0]    phys
);

  reg_region_e    region;
  logic [WW-1:0]  offset;
  logic [WW-1:0]  rotated;

  always_comb begin
    region  = reg_region_e'(idx[IDX_W-1 -: 2]);
    offset  = WW'(idx) - WW'(NGRP);
    // Truncation to WW bits wraps the window ring (WREGS is a power of two)
    rotated = (WW'(cwp) << SB) + offset;
    if (region == RGN_GLOBAL) begin
      phys = PW'(idx);
    end else begin
      phys = PW'(rotated) + PW'(NGRP);
    end
  end

endmodule

// File: rtl/winreg_ptr.sv
module winreg_ptr
  import winreg_pkg::*;
#(
  parameter int NWIN        = 8,
  parameter int WIM_RST_WIN = 1,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_data,
  output logic [CW-1:0]   cwp_q,
  output logic            ovf_q,
  output logic            unf_q
);

  localparam logic [CW-1:0]   LAST_WIN = CW'(NWIN - 1);
  localparam logic [NWIN-1:0] WIM_RST  = NWIN'(1) << WIM_RST_WIN;

  win_step_e       step;
  logic [CW-1:0]   dec_win;
  logic [CW-1:0]   inc_win;
  logic [NWIN-1:0] wim_q;

  always_comb begin
    step    = decode_step(save_req, restore_req);
    dec_win = (cwp_q == '0)       ? LAST_WIN : cwp_q - CW'(1);
    inc_win = (cwp_q == LAST_WIN) ? '0       : cwp_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      wim_q <= WIM_RST;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      case (step)
        WSTEP_SAVE: begin
          if (wim_q[dec_win]) ovf_q <= 1'b1;
          else                cwp_q <= dec_win;
        end
        WSTEP_RESTORE: begin
          if (wim_q[inc_win]) unf_q <= 1'b1;
          else                cwp_q <= inc_win;
        end
        default: ;
      endcase
      if (wim_we) wim_q <= wim_data;
    end
  end

  assert_save_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step == WSTEP_SAVE && !wim_q[dec_win]) |=> (cwp_q == $past(dec_win)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (step == WSTEP_HOLD) |=> $stable(cwp_q));

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $stable(cwp_q));

  assert_unf_hold_R8: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> $stable(cwp_q));

  assert_both_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (step == WSTEP_BOTH) |=> (!ovf_q && !unf_q && $stable(cwp_q)));

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int DATA_W = 32,
  parameter int NPHYS  = 136,
  parameter int NRD    = 2,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PW-1:0]              wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NRD-1:0][PW-1:0]     rd_addr,
  output logic [NRD-1:0][DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [0:NPHYS-1];
  logic              wr_live;

  // Physical entry 0 is the zero register and is never written
  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[g] <= '0;
      end else if (wr_live && (wr_addr == rd_addr[g])) begin
        rd_data[g] <= wr_data;
      end else begin
        rd_data[g] <= mem[rd_addr[g]];
      end
    end

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_addr[g] == '0) |=> (rd_data[g] == '0));

    assert_write_first_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0 && wr_addr == rd_addr[g]) |=> (rd_data[g] == $past(wr_data)));
  end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DATA_W      = 32,
  parameter int NWIN        = 8,
  parameter int NGRP        = 8,
  parameter int WIM_RST_WIN = 1,
  localparam int IDX_W = $clog2(4 * NGRP),
  localparam int CW    = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rs1_idx,
  input  logic [IDX_W-1:0]  rs2_idx,
  output logic [DATA_W-1:0] rs1_data,
  output logic [DATA_W-1:0] rs2_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic              wim_we,
  input  logic [NWIN-1:0]   wim_data,
  output logic [CW-1:0]     cwp,
  output logic              ovf_trap,
  output logic              unf_trap
);

  localparam int NPHYS = NGRP + NWIN * 2 * NGRP;
  localparam int PW    = $clog2(NPHYS);
  localparam int NPORT = 3;   // two reads, one write

  logic [NPORT-1:0][IDX_W-1:0]  log_idx;
  logic [NPORT-1:0][PW-1:0]     phys_idx;
  logic [1:0][PW-1:0]           rd_addr;
  logic [1:0][DATA_W-1:0]       rd_data;

  assign log_idx = {wr_idx, rs2_idx, rs1_idx};

  winreg_ptr #(
    .NWIN        (NWIN),
    .WIM_RST_WIN (WIM_RST_WIN)
  ) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .wim_we      (wim_we),
    .wim_data    (wim_data),
    .cwp_q       (cwp),
    .ovf_q       (ovf_trap),
    .unf_q       (unf_trap)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_map #(
      .NWIN (NWIN),
      .NGRP (NGRP)
    ) u_map (
      .cwp  (cwp),
      .idx  (log_idx[p]),
      .phys (phys_idx[p])
    );
  end

  assign rd_addr = {phys_idx[1], phys_idx[0]};

  winreg_bank #(
    .DATA_W (DATA_W),
    .NPHYS  (NPHYS),
    .NRD    (2)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (phys_idx[2]),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign rs1_data = rd_data[0];
  assign rs2_data = rd_data[1];

  assert_traps_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(ovf_trap && unf_trap));

endmodule

// File: tb/winreg_file_tb.sv
module winreg_file_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rs1_idx, rs2_idx, wr_idx;
  logic [31:0] rs1_data, rs2_data, wr_data;
  logic        wr_en, save_req, restore_req, wim_we;
  logic [7:0]  wim_data;
  logic [2:0]  cwp;
  logic        ovf_trap, unf_trap;

  always #5 clk = ~clk;

  winreg_file u_dut (
    .clk(clk), .rst(rst),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rs1_data(rs1_data), .rs2_data(rs2_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .wim_we(wim_we), .wim_data(wim_data),
    .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] ref_mem [0:135];
  int          ref_cwp;
  logic [7:0]  ref_wim;

  function automatic int phys_of(input int w, input int idx);
    if (idx < 8) return idx;
    return ((w * 16 + idx - 8) % 128) + 8;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One cycle: drive at negedge, model, check at the following negedge
  task automatic do_cycle(input string tag,
                          input logic we, input int wi, input logic [31:0] wd,
                          input int a1, input int a2,
                          input logic sv, input logic rs,
                          input logic mwe, input logic [7:0] md);
    logic [31:0] e1, e2;
    logic        eo, eu;
    int          p1, p2, pw, nxt;
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    rs1_idx = 5'(a1); rs2_idx = 5'(a2);
    save_req = sv; restore_req = rs;
    wim_we = mwe; wim_data = md;
    p1 = phys_of(ref_cwp, a1);
    p2 = phys_of(ref_cwp, a2);
    pw = phys_of(ref_cwp, wi);
    e1 = (we && pw != 0 && pw == p1) ? wd : ref_mem[p1];
    e2 = (we && pw != 0 && pw == p2) ? wd : ref_mem[p2];
    eo = 0; eu = 0;
    if (we && pw != 0) ref_mem[pw] = wd;
    if (sv && !rs) begin
      nxt = (ref_cwp + 7) % 8;
      if (ref_wim[nxt]) eo = 1; else ref_cwp = nxt;
    end else if (rs && !sv) begin
      nxt = (ref_cwp + 1) % 8;
      if (ref_wim[nxt]) eu = 1; else ref_cwp = nxt;
    end
    if (mwe) ref_wim = md;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rs1_data", rs1_data, e1);
    chk(tag, "rs2_data", rs2_data, e2);
    chk(tag, "cwp", 32'(cwp), 32'(ref_cwp));
    chk(tag, "ovf_trap", 32'(ovf_trap), 32'(eo));
    chk(tag, "unf_trap", 32'(unf_trap), 32'(eu));
    wr_en = 0; save_req = 0; restore_req = 0; wim_we = 0;
  endtask

  task automatic rd(input string tag, input int a1, input int a2);
    do_cycle(tag, 0, 0, 0, a1, a2, 0, 0, 0, 0);
  endtask

  task automatic wr(input string tag, input int wi, input logic [31:0] wd);
    do_cycle(tag, 1, wi, wd, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 136; i++) ref_mem[i] = '0;
    ref_cwp = 0;
    ref_wim = 8'b0000_0010;
    rst = 1; wr_en = 0; wr_idx = 0; wr_data = 0; rs1_idx = 0; rs2_idx = 0;
    save_req = 0; restore_req = 0; wim_we = 0; wim_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state at the ports
    chk("R1", "cwp", 32'(cwp), 0);
    chk("R1", "ovf_trap", 32'(ovf_trap), 0);
    chk("R1", "unf_trap", 32'(unf_trap), 0);
    chk("R1", "rs1_data", rs1_data, 0);
    for (int i = 0; i < 32; i += 2) rd("R1", i, i + 1);
    // R1: mask marks window 1 only: restore from 0 traps
    do_cycle("R1", 0, 0, 0, 0, 0, 0, 1, 0, 0);

    // R11: two reads and a write per cycle
    wr("R11", 5, 32'hAAAA_0005);
    wr("R11", 10, 32'hBBBB_000A);
    wr("R11", 18, 32'hCCCC_0012);
    wr("R11", 26, 32'hDDDD_001A);
    rd("R11", 5, 10);
    rd("R11", 18, 26);

    // R3: global 0 is fixed at zero, also with a same-cycle read
    do_cycle("R3", 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    rd("R3", 0, 5);

    // R6: save from window 0 wraps to 7
    do_cycle("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R4: incoming 26 in window 7 is outgoing 10 of window 0
    rd("R4", 26, 10);
    // R2: global 5 unchanged; R5: local 18 private to window 7
    rd("R2", 5, 18);
    rd("R5", 18, 18);
    wr("R5", 18, 32'hEEEE_0712);
    wr("R4", 27, 32'h1234_5678);
    // R6: restore from 7 wraps to 0
    do_cycle("R6", 0, 0, 0, 18, 10, 0, 1, 0, 0);
    rd("R5", 18, 5);
    rd("R4", 11, 10);

    // R8: restore into window 1 is blocked
    do_cycle("R8", 0, 0, 0, 5, 5, 0, 1, 0, 0);
    rd("R8", 18, 18);

    // R6/R7: save down to window 2, then the next save traps
    for (int i = 0; i < 6; i++) begin
      do_cycle("R6", 1, 16 + i, 32'h5000_0000 + i, 16 + i, 24, 1, 0, 0, 0);
    end
    do_cycle("R7", 0, 0, 0, 16, 24, 1, 0, 0, 0);
    rd("R7", 16, 17);

    // R12: reload mask so only window 0 is invalid
    do_cycle("R12", 0, 0, 0, 0, 0, 0, 0, 1, 8'b0000_0001);
    do_cycle("R12", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    do_cycle("R12", 0, 0, 0, 0, 0, 1, 0, 0, 0);

    // R9: both strobes at once
    do_cycle("R9", 0, 0, 0, 0, 0, 1, 1, 0, 0);

    // R10: same-cycle write and read, including a read on both ports
    do_cycle("R10", 1, 20, 32'hF00D_0014, 20, 20, 0, 0, 0, 0);
    do_cycle("R10", 1, 9, 32'hF00D_0009, 9, 5, 0, 0, 0, 0);
    do_cycle("R10", 1, 3, 32'hF00D_0003, 1, 3, 0, 0, 0, 0);

    // R11: random mix against the model
    for (int n = 0; n < 1500; n++) begin
      int wi, a1, a2;
      logic sv, rs, mwe;
      logic [7:0] md;
      wi = int'($urandom % 32);
      a1 = ($urandom % 4 == 0) ? wi : int'($urandom % 32);
      a2 = int'($urandom % 32);
      sv = ($urandom % 6 == 0);
      rs = ($urandom % 6 == 0);
      mwe = ($urandom % 40 == 0);
      md = 8'($urandom) & 8'($urandom);
      do_cycle("R11", ($urandom % 2 == 0), wi, $urandom, a1, a2, sv, rs, mwe, md);
    end

    finish_run();
  end

endmodule